// File: doc/BRIEF.md
# Debug Serial Port with Channel Test Modes

This block is a two-wire asynchronous serial port for debug consoles and boot monitors. One data input pin and one data output pin carry frames to and from a host. Inside, a transmitter and a receiver work independently. Both take their timing from one shared programmable divider, which produces a tick at sixteen times the bit rate. Each frame has a low start bit, eight data bits sent least-significant first, an optional parity bit and a high stop bit. The line rests high when idle.

Software, or a DMA engine, talks to the port through a small holding-register interface. A transmit holding register comes with a ready flag and a write strobe. A receive holding register comes with a ready flag and a read strobe. Three sticky error flags are cleared by a clear strobe. Two level requests mirror the ready flags for DMA channels. A channel-mode input reroutes the serial paths for testing: automatic echo, internal loopback, or pin-to-pin loopback.

Top module: `dbgp_uart`

## Requirements
- R1: After reset, tx_ready and dma_tx_req are 1, rx_ready and dma_rx_req are 0, all three error flags are 0, and ser_out is 1.
- R2: A transmitted frame is one start bit at 0, then tx_data bits 0 to 7 in that order, then the parity bit when parity is enabled, then a stop bit at 1. The line is 1 between frames.
- R3: Each bit lasts 16 × divisor clock cycles (a start bit lasts 32 cycles at divisor 2). When divisor is 0, no frame starts, tx_ready stays 0 after a write, and ser_out stays 1. Transmission resumes once divisor is made non-zero.
- R4: parity_mode codes are: 0 no parity bit, 1 even (the parity bit makes the count of ones even), 2 odd, 3 mark (parity bit always 1), 4 space (parity bit always 0).
- R5: A frame received in full loads rx_data and sets rx_ready and dma_rx_req. A one-cycle rx_rd pulse clears rx_ready.
- R6: A received parity bit that disagrees with the selected parity mode sets err_parity. It never does so when parity_mode is 0.
- R7: A stop bit sampled at 0 sets err_frame. The character is still delivered to rx_data.
- R8: If a frame completes while rx_ready is still 1 and no read occurs in that cycle, err_overrun is set and rx_data takes the newer character.
- R9: A clr_status pulse clears all three error flags on the next clock edge. The clear wins over a new error set in the same cycle.
- R10: A low pulse on the receive line shorter than half a bit is rejected as a false start and produces no character.
- R11: chan_mode codes are: 0 normal, 1 automatic echo, 2 local loopback, 3 remote loopback. In echo mode (1), ser_out follows ser_in, the transmitter does not reach the pin, and the receiver still receives from ser_in.
- R12: In local loopback (2), the transmitter output feeds the receiver, ser_in is ignored, and ser_out is held at 1.
- R13: In remote loopback (3), ser_out follows ser_in, and both the receiver and the transmitter are cut off from the line, so no character is received.
- R14: tx_ready and dma_tx_req fall on the cycle after an accepted write, and rise again once the byte moves into the shifter. A write while tx_ready is 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| divisor | input | 16 | Baud divisor; 0 stops the baud tick |
| parity_mode | input | 3 | Parity selection (see R4) |
| chan_mode | input | 2 | Channel routing selection (see R11) |
| tx_wr | input | 1 | Write strobe for the transmit holding register |
| tx_data | input | 8 | Byte to transmit |
| tx_ready | output | 1 | Transmit holding register empty |
| rx_rd | input | 1 | Read strobe, acknowledges rx_data |
| rx_data | output | 8 | Last received byte |
| rx_ready | output | 1 | Unread received byte present |
| clr_status | input | 1 | Clears the error flags |
| err_parity | output | 1 | Sticky parity error |
| err_frame | output | 1 | Sticky framing error |
| err_overrun | output | 1 | Sticky overrun error |
| dma_tx_req | output | 1 | Level request: transmitter can accept a byte |
| dma_rx_req | output | 1 | Level request: received byte waiting |
| ser_in | input | 1 | Serial data input pin |
| ser_out | output | 1 | Serial data output pin |

## Verification
The bench aims at the edges of the receive timing. A two-tick low glitch must not start a frame; a sampler without mid-bit confirmation would turn it into a phantom character. A stop bit held low is followed by a long low line, which catches a receiver that starts a false frame from that level or drops the bad character. Back-to-back frames with no read show whether the newer byte overwrites the old one and whether overrun is flagged. A third write into a full holding register shows whether a dropped write leaks out as an extra frame. In each loopback mode, the pin that should be silent or mirrored is compared every cycle, while the transmitter is busy driving a pattern that would show through any wrong route.

// File: rtl/dbgp_pkg.sv
package dbgp_pkg;

  typedef enum logic [2:0] {
    PAR_NONE  = 3'd0,
    PAR_EVEN  = 3'd1,
    PAR_ODD   = 3'd2,
    PAR_MARK  = 3'd3,
    PAR_SPACE = 3'd4
  } par_mode_e;

  typedef enum logic [1:0] {
    CH_NORMAL = 2'd0,
    CH_ECHO   = 2'd1,
    CH_LOCAL  = 2'd2,
    CH_REMOTE = 2'd3
  } chan_mode_e;

  // true when the frame carries a parity bit
  function automatic logic has_parity(par_mode_e m);
    return (m == PAR_EVEN) || (m == PAR_ODD) || (m == PAR_MARK) || (m == PAR_SPACE);
  endfunction

  // parity bit value given the xor-reduction of the data bits
  function automatic logic parity_value(par_mode_e m, logic data_xor);
    case (m)
      PAR_EVEN:  return data_xor;
      PAR_ODD:   return ~data_xor;
      PAR_MARK:  return 1'b1;
      default:   return 1'b0;
    endcase
  endfunction

  // number of bit slots in one frame: start + data + parity + stop
  function automatic int unsigned frame_slots(par_mode_e m, int unsigned dw);
    return dw + 32'd2 + (has_parity(m) ? 32'd1 : 32'd0);
  endfunction

endpackage

// File: rtl/dbgp_baud.sv
module dbgp_baud #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (divisor == '0) begin
      cnt_q <= '0;
    end else if (cnt_q == '0) begin
      cnt_q <= divisor - 1'b1;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign tick = (divisor != '0) && (cnt_q == '0);
endmodule

// File: rtl/dbgp_tx.sv
module dbgp_tx
  import dbgp_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  par_mode_e         pmode,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic              ready,
  output logic              line
);
  localparam int unsigned FW = DATA_W + 3;
  localparam int unsigned CW = $clog2(OVERSAMPLE);
  localparam int unsigned BW = $clog2(DATA_W + 4);

  logic [DATA_W-1:0] hold_q;
  logic              hold_full_q;
  logic [FW-1:0]     shift_q;
  logic [CW-1:0]     os_q;
  logic [BW-1:0]     left_q;
  logic              busy_q;
  logic              pbit;
  logic              load;

  assign pbit  = parity_value(pmode, ^hold_q);
  assign load  = tick && !busy_q && hold_full_q;
  assign ready = !hold_full_q;
  assign line  = busy_q ? shift_q[0] : 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q      <= '0;
      hold_full_q <= 1'b0;
      shift_q     <= '1;
      os_q        <= '0;
      left_q      <= '0;
      busy_q      <= 1'b0;
    end else begin
      if (wr && !hold_full_q) begin
        hold_q      <= wdata;
        hold_full_q <= 1'b1;
      end
      if (load) begin
        hold_full_q <= 1'b0;
        busy_q      <= 1'b1;
        os_q        <= '0;
        left_q      <= BW'(frame_slots(pmode, DATA_W));
        if (has_parity(pmode)) shift_q <= {1'b1, pbit, hold_q, 1'b0};
        else                   shift_q <= {2'b11, hold_q, 1'b0};
      end else if (tick && busy_q) begin
        if (os_q == CW'(OVERSAMPLE - 1)) begin
          os_q    <= '0;
          shift_q <= {1'b1, shift_q[FW-1:1]};
          left_q  <= left_q - 1'b1;
          if (left_q == BW'(1)) busy_q <= 1'b0;
        end else begin
          os_q <= os_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dbgp_rx.sv
module dbgp_rx
  import dbgp_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  par_mode_e         pmode,
  input  logic              line,
  output logic              done,
  output logic [DATA_W-1:0] char_out,
  output logic              par_bad,
  output logic              stop_bad
);
  localparam int unsigned CW = $clog2(OVERSAMPLE);
  localparam int unsigned IW = $clog2(DATA_W + 2);

  typedef enum logic [1:0] {S_IDLE, S_START, S_BITS, S_WAITHI} rx_state_e;

  rx_state_e         st_q;
  logic [CW-1:0]     os_q;
  logic [IW-1:0]     idx_q;
  logic [DATA_W-1:0] sh_q;
  logic              pbit_q;
  logic [IW-1:0]     last_idx;
  logic              bit_mid;

  assign last_idx = has_parity(pmode) ? IW'(DATA_W + 1) : IW'(DATA_W);
  assign bit_mid  = tick && (os_q == CW'(OVERSAMPLE - 1));
  assign done     = (st_q == S_BITS) && bit_mid && (idx_q == last_idx);
  assign char_out = sh_q;
  assign stop_bad = done && !line;
  assign par_bad  = done && has_parity(pmode) && (pbit_q != parity_value(pmode, ^sh_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      os_q   <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
      pbit_q <= 1'b0;
    end else begin
      case (st_q)
        S_IDLE: begin
          if (tick && !line) begin
            st_q <= S_START;
            os_q <= '0;
          end
        end
        S_START: begin
          if (tick) begin
            if (os_q == CW'(OVERSAMPLE / 2 - 1)) begin
              os_q  <= '0;
              idx_q <= '0;
              st_q  <= line ? S_IDLE : S_BITS;
            end else begin
              os_q <= os_q + 1'b1;
            end
          end
        end
        S_BITS: begin
          if (tick) begin
            if (bit_mid) begin
              os_q  <= '0;
              idx_q <= idx_q + 1'b1;
              if (idx_q < IW'(DATA_W)) sh_q <= {line, sh_q[DATA_W-1:1]};
              else if (idx_q != last_idx) pbit_q <= line;
              if (done) st_q <= line ? S_IDLE : S_WAITHI;
            end else begin
              os_q <= os_q + 1'b1;
            end
          end
        end
        default: begin
          if (line) st_q <= S_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/dbgp_uart.sv
module dbgp_uart
  import dbgp_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DIV_W = 16,
  parameter int unsigned OVERSAMPLE = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  divisor,
  input  logic [2:0]        parity_mode,
  input  logic [1:0]        chan_mode,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_ready,
  input  logic              rx_rd,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_ready,
  input  logic              clr_status,
  output logic              err_parity,
  output logic              err_frame,
  output logic              err_overrun,
  output logic              dma_tx_req,
  output logic              dma_rx_req,
  input  logic              ser_in,
  output logic              ser_out
);
  par_mode_e  pmode;
  chan_mode_e cmode;
  assign pmode = par_mode_e'(parity_mode);
  assign cmode = chan_mode_e'(chan_mode);

  logic              tick16;
  logic              tx_line;
  logic              rx_src;
  logic              rx_line;
  logic              rx_done;
  logic [DATA_W-1:0] rx_char;
  logic              rx_par_bad;
  logic              rx_stop_bad;
  logic [SYNC_STAGES-1:0] sync_q;

  dbgp_baud #(.DIV_W(DIV_W)) i_baud (
    .clk(clk), .rst_n(rst_n), .divisor(divisor), .tick(tick16)
  );

  dbgp_tx #(.DATA_W(DATA_W), .OVERSAMPLE(OVERSAMPLE)) i_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .pmode(pmode),
    .wr(tx_wr), .wdata(tx_data), .ready(tx_ready), .line(tx_line)
  );

  // channel routing between pins, transmitter and receiver
  always_comb begin
    case (cmode)
      CH_ECHO:   begin ser_out = ser_in; rx_src = ser_in;  end
      CH_LOCAL:  begin ser_out = 1'b1;   rx_src = tx_line; end
      CH_REMOTE: begin ser_out = ser_in; rx_src = 1'b1;    end
      default:   begin ser_out = tx_line; rx_src = ser_in; end
    endcase
  end

  // input synchronizer, resets to idle level
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= rx_src;
      end
    end else begin : g_syncn
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], rx_src};
      end
    end
  endgenerate
  assign rx_line = sync_q[SYNC_STAGES-1];

  dbgp_rx #(.DATA_W(DATA_W), .OVERSAMPLE(OVERSAMPLE)) i_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .pmode(pmode), .line(rx_line),
    .done(rx_done), .char_out(rx_char), .par_bad(rx_par_bad), .stop_bad(rx_stop_bad)
  );

  // receive holding register and sticky status
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_data     <= '0;
      rx_ready    <= 1'b0;
      err_parity  <= 1'b0;
      err_frame   <= 1'b0;
      err_overrun <= 1'b0;
    end else begin
      if (rx_done) begin
        rx_data  <= rx_char;
        rx_ready <= 1'b1;
      end else if (rx_rd) begin
        rx_ready <= 1'b0;
      end
      if (clr_status) begin
        err_parity  <= 1'b0;
        err_frame   <= 1'b0;
        err_overrun <= 1'b0;
      end else begin
        if (rx_par_bad)                      err_parity  <= 1'b1;
        if (rx_stop_bad)                     err_frame   <= 1'b1;
        if (rx_done && rx_ready && !rx_rd)   err_overrun <= 1'b1;
      end
    end
  end

  assign dma_tx_req = tx_ready;
  assign dma_rx_req = rx_ready;
endmodule

// File: rtl/dbgp_uart_chk.sv
module dbgp_uart_chk #(
  parameter int unsigned DIV_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [DIV_W-1:0] divisor,
  input logic             tick16,
  input logic             tx_wr,
  input logic             tx_ready,
  input logic             rx_done,
  input logic             rx_ready,
  input logic             clr_status,
  input logic             err_parity,
  input logic             err_frame,
  input logic             err_overrun
);
  // R14
  wr_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr && tx_ready) |=> !tx_ready);

  // R3
  halted_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((divisor == '0) && $past(divisor == '0)) |-> !tick16);

  // R5
  ready_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ready) |-> $past(rx_done));

  // R9
  status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_status |=> (!err_parity && !err_frame && !err_overrun));

  // R8
  overrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_overrun) |-> $past(rx_done && rx_ready));

  // R7
  frame_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_frame) |-> $past(rx_done));
endmodule

bind dbgp_uart dbgp_uart_chk #(.DIV_W(DIV_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .divisor(divisor), .tick16(tick16),
  .tx_wr(tx_wr), .tx_ready(tx_ready), .rx_done(rx_done), .rx_ready(rx_ready),
  .clr_status(clr_status), .err_parity(err_parity), .err_frame(err_frame),
  .err_overrun(err_overrun)
);

// File: tb/test_dbgp_uart.sv
`timescale 1ns/1ps
module test_dbgp_uart;
  localparam int DIV = 2;
  localparam int BIT = 16 * DIV;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] divisor = 16'(DIV);
  logic [2:0]  parity_mode = 3'd0;
  logic [1:0]  chan_mode = 2'd0;
  logic        tx_wr = 1'b0;
  logic [7:0]  tx_data = 8'h00;
  logic        tx_ready;
  logic        rx_rd = 1'b0;
  logic [7:0]  rx_data;
  logic        rx_ready;
  logic        clr_status = 1'b0;
  logic        err_parity, err_frame, err_overrun;
  logic        dma_tx_req, dma_rx_req;
  logic        ser_in = 1'b1;
  logic        ser_out;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  dbgp_uart i_dbgp_uart (
    .clk(clk), .rst_n(rst_n), .divisor(divisor), .parity_mode(parity_mode),
    .chan_mode(chan_mode), .tx_wr(tx_wr), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_rd(rx_rd), .rx_data(rx_data), .rx_ready(rx_ready), .clr_status(clr_status),
    .err_parity(err_parity), .err_frame(err_frame), .err_overrun(err_overrun),
    .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req), .ser_in(ser_in), .ser_out(ser_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic bench_par(input logic [2:0] m, input logic [7:0] b);
    int ones = 0;
    for (int i = 0; i < 8; i++) ones += int'(b[i]);
    case (m)
      3'd1: return (ones % 2) == 1;
      3'd2: return (ones % 2) == 0;
      3'd3: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic write_tx(input logic [7:0] b);
    tx_data = b; tx_wr = 1'b1;
    cyc(1);
    tx_wr = 1'b0;
  endtask

  task automatic pulse_clr();
    clr_status = 1'b1; cyc(1); clr_status = 1'b0;
  endtask

  task automatic pulse_rd();
    rx_rd = 1'b1; cyc(1); rx_rd = 1'b0;
  endtask

  task automatic drive_frame(input logic [7:0] b, input logic flip_par, input logic stop_val);
    ser_in = 1'b0; cyc(BIT);
    for (int i = 0; i < 8; i++) begin ser_in = b[i]; cyc(BIT); end
    if (parity_mode != 3'd0) begin
      ser_in = bench_par(parity_mode, b) ^ flip_par; cyc(BIT);
    end
    ser_in = stop_val; cyc(BIT);
    ser_in = 1'b1;
  endtask

  task automatic capture(output logic [7:0] d, output logic p, output logic stp, output logic found);
    int t = 0;
    found = 1'b0; d = 8'h00; p = 1'b0; stp = 1'b0;
    while (ser_out !== 1'b0 && t < 4000) begin cyc(1); t++; end
    if (ser_out === 1'b0) begin
      found = 1'b1;
      cyc(BIT / 2);
      for (int i = 0; i < 8; i++) begin cyc(BIT); d[i] = ser_out; end
      if (parity_mode != 3'd0) begin cyc(BIT); p = ser_out; end
      cyc(BIT); stp = ser_out;
    end
  endtask

  task automatic t_reset();
    chk("R1 tx_ready", 32'(tx_ready), 1);
    chk("R1 dma_tx_req", 32'(dma_tx_req), 1);
    chk("R1 rx_ready", 32'(rx_ready), 0);
    chk("R1 dma_rx_req", 32'(dma_rx_req), 0);
    chk("R1 errors", {29'd0, err_parity, err_frame, err_overrun}, 0);
    chk("R1 ser_out", 32'(ser_out), 1);
  endtask

  task automatic t_bit_time();
    int n = 0, t = 0;
    parity_mode = 3'd0;
    write_tx(8'h01);
    while (ser_out !== 1'b0 && t < 200) begin cyc(1); t++; end
    while (ser_out === 1'b0 && n < 1000) begin n++; cyc(1); end
    chk("R3 start bit length", 32'(n), 32'(BIT));
    cyc(12 * BIT);
  endtask

  task automatic t_tx_frames();
    logic [7:0] bytes [5] = '{8'h3C, 8'h81, 8'h00, 8'hFF, 8'h96};
    logic [7:0] d; logic p, s, f;
    for (int k = 0; k < 5; k++) begin
      parity_mode = 3'(k);
      write_tx(bytes[k]);
      chk("R14 tx_ready low after write", 32'(tx_ready), 0);
      chk("R14 dma_tx_req low after write", 32'(dma_tx_req), 0);
      capture(d, p, s, f);
      chk("R2 frame seen", 32'(f), 1);
      chk("R2 data lsb first", 32'(d), 32'(bytes[k]));
      if (k != 0) chk("R4 parity bit", 32'(p), 32'(bench_par(3'(k), bytes[k])));
      chk("R2 stop bit", 32'(s), 1);
      chk("R14 tx_ready back", 32'(tx_ready), 1);
      cyc(BIT);
    end
  endtask

  task automatic t_rx_basic();
    parity_mode = 3'd1;
    drive_frame(8'h5A, 1'b0, 1'b1);
    cyc(4);
    chk("R5 rx_ready", 32'(rx_ready), 1);
    chk("R5 dma_rx_req", 32'(dma_rx_req), 1);
    chk("R5 rx_data", 32'(rx_data), 32'h5A);
    chk("R6 no parity error", 32'(err_parity), 0);
    pulse_rd();
    chk("R5 rx_ready cleared", 32'(rx_ready), 0);
    parity_mode = 3'd0;
    drive_frame(8'hC7, 1'b0, 1'b1);
    cyc(4);
    chk("R5 no-parity rx_data", 32'(rx_data), 32'hC7);
    chk("R6 no error without parity", 32'(err_parity), 0);
    pulse_rd();
  endtask

  task automatic t_parity_err();
    parity_mode = 3'd2;
    drive_frame(8'h37, 1'b1, 1'b1);
    cyc(4);
    chk("R6 odd parity error", 32'(err_parity), 1);
    chk("R6 no frame error", 32'(err_frame), 0);
    pulse_clr();
    chk("R9 parity cleared", 32'(err_parity), 0);
    pulse_rd();
    parity_mode = 3'd4;
    drive_frame(8'hE1, 1'b0, 1'b1);
    cyc(4);
    chk("R6 space parity good", 32'(err_parity), 0);
    chk("R5 space rx_data", 32'(rx_data), 32'hE1);
    pulse_rd();
    parity_mode = 3'd3;
    drive_frame(8'h22, 1'b1, 1'b1);
    cyc(4);
    chk("R6 mark parity error", 32'(err_parity), 1);
    pulse_clr(); pulse_rd();
  endtask

  task automatic t_frame_err();
    parity_mode = 3'd0;
    drive_frame(8'h4B, 1'b0, 1'b0);
    ser_in = 1'b0; cyc(2 * BIT);
    ser_in = 1'b1; cyc(3 * BIT);
    chk("R7 frame error", 32'(err_frame), 1);
    chk("R7 char delivered", 32'(rx_data), 32'h4B);
    pulse_rd();
    cyc(2);
    chk("R7 no phantom char", 32'(rx_ready), 0);
    pulse_clr();
    chk("R9 frame cleared", 32'(err_frame), 0);
  endtask

  task automatic t_overrun();
    parity_mode = 3'd0;
    drive_frame(8'h11, 1'b0, 1'b1);
    cyc(4);
    chk("R8 no overrun yet", 32'(err_overrun), 0);
    drive_frame(8'h22, 1'b0, 1'b1);
    cyc(4);
    chk("R8 overrun set", 32'(err_overrun), 1);
    chk("R8 newer kept", 32'(rx_data), 32'h22);
    pulse_clr();
    chk("R9 overrun cleared", 32'(err_overrun), 0);
    pulse_rd();
  endtask

  task automatic t_glitch();
    ser_in = 1'b0; cyc(4); ser_in = 1'b1;
    cyc(3 * BIT);
    chk("R10 glitch rejected", 32'(rx_ready), 0);
    drive_frame(8'h6D, 1'b0, 1'b1);
    cyc(4);
    chk("R10 next frame intact", 32'(rx_data), 32'h6D);
    pulse_rd();
  endtask

  task automatic t_echo();
    int mism = 0;
    chan_mode = 2'd1; parity_mode = 3'd0;
    write_tx(8'h00);
    fork
      drive_frame(8'hC3, 1'b0, 1'b1);
      repeat (10 * BIT) begin
        @(negedge clk); #2;
        if (ser_out !== ser_in) mism++;
      end
    join
    cyc(4);
    chk("R11 echo follows input", 32'(mism), 0);
    chk("R11 echo receiver data", 32'(rx_data), 32'hC3);
    pulse_rd();
    cyc(12 * BIT);
    chan_mode = 2'd0;
  endtask

  task automatic t_local();
    int lows = 0, t = 0;
    parity_mode = 3'd1;
    chan_mode = 2'd2;
    cyc(2);
    ser_in = 1'b0;
    write_tx(8'hA5);
    while (rx_ready !== 1'b1 && t < 4000) begin
      cyc(1); t++;
      if (ser_out !== 1'b1) lows++;
    end
    chk("R12 looped char", 32'(rx_data), 32'hA5);
    chk("R12 ser_out held high", 32'(lows), 0);
    chk("R12 no errors", {29'd0, err_parity, err_frame, err_overrun}, 0);
    pulse_rd();
    cyc(2 * BIT);
    ser_in = 1'b1;
    cyc(2);
    chan_mode = 2'd0;
    cyc(2);
  endtask

  task automatic t_remote();
    int mism = 0;
    chan_mode = 2'd3; parity_mode = 3'd0;
    write_tx(8'h00);
    fork
      drive_frame(8'h0F, 1'b0, 1'b1);
      repeat (10 * BIT) begin
        @(negedge clk); #2;
        if (ser_out !== ser_in) mism++;
      end
    join
    cyc(4);
    chk("R13 pin to pin", 32'(mism), 0);
    chk("R13 receiver cut off", 32'(rx_ready), 0);
    cyc(12 * BIT);
    chan_mode = 2'd0;
  endtask

  task automatic t_div_zero();
    int lows = 0;
    logic [7:0] d; logic p, s, f;
    parity_mode = 3'd0;
    divisor = 16'd0;
    cyc(2);
    write_tx(8'h55);
    repeat (200) begin cyc(1); if (ser_out !== 1'b1) lows++; end
    chk("R3 halted tx_ready", 32'(tx_ready), 0);
    chk("R3 halted line", 32'(lows), 0);
    divisor = 16'(DIV);
    capture(d, p, s, f);
    chk("R3 resumes", 32'(d), 32'h55);
    cyc(BIT);
  endtask

  task automatic t_full();
    int lows = 0, t = 0;
    logic [7:0] d; logic p, s, f;
    parity_mode = 3'd0;
    write_tx(8'h10);
    while (tx_ready !== 1'b1 && t < 100) begin cyc(1); t++; end
    write_tx(8'h20);
    write_tx(8'h30);
    chk("R14 still full", 32'(tx_ready), 0);
    capture(d, p, s, f);
    chk("R14 first byte", 32'(d), 32'h10);
    capture(d, p, s, f);
    chk("R14 second byte", 32'(d), 32'h20);
    repeat (15 * BIT) begin cyc(1); if (ser_out !== 1'b1) lows++; end
    chk("R14 dropped write not sent", 32'(lows), 0);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    t_reset();
    t_bit_time();
    t_tx_frames();
    t_rx_basic();
    t_parity_err();
    t_frame_err();
    t_overrun();
    t_glitch();
    t_echo();
    t_local();
    t_remote();
    t_div_zero();
    t_full();
    finish_run();
  end
endmodule